// File: doc/BRIEF.md
# Iterative Modular Exponentiation Engine

The engine raises a base to an exponent modulo a modulus, with all operands up to 32 bits wide. It serves RSA-style encryption and decryption. The same hardware does both jobs, and only the exponent changes between them. A start strobe captures the three operands while the engine is idle. The engine raises a busy flag while it works. When the answer is ready it drops busy, presents the result and pulses done for a single cycle.

The exponent is treated as a count of passes, not scanned bit by bit. The running value begins at the base reduced modulo n. Each further pass multiplies the running value by that reduced base and reduces the product again, so the full power is never formed. Every modular multiply is an interleaved shift-add-subtract loop that consumes one multiplier bit per cycle, so no divider and no wide multiplier is needed. Latency is therefore a fixed multiple of the exponent's value: a large private exponent costs proportionally more cycles than a small public one.

Top module: `modexp_engine`

## Requirements
- R1: After a run, `result_o` equals base^exp mod n for any 32-bit operands with n >= 2. Examples: 123^17 mod 3233 = 855, 0x64^3 mod 0x21 = 1, and 0xFFFFFFFA^3 mod 0xFFFFFFFB = 0xFFFFFFFA.
- R2: The same engine, used with the private exponent, inverts encryption: 855^2753 mod 3233 = 123, which is 0x357^0xAC1 mod 0xCA1 = 0x7B.
- R3: With base 123 and modulus 3233, exponents 1 through 5 give 123, 2197, 1892, 3173 and 2319 in that order.
- R4: An exponent of 0 with n >= 2 gives 1.
- R5: A modulus of 0 or 1 gives result 0. In that case done is high in the cycle right after the start cycle and busy never rises.
- R6: A base equal to or larger than the modulus is first reduced modulo n. For example, base 3356 with exponent 17 and modulus 3233 gives 855.
- R7: For n >= 2, busy is high for exactly 32 x max(exp, 1) cycles, starting the cycle after start. Done is high only in the single cycle after the last busy cycle, and done and busy are never high together.
- R8: A start pulse while busy is high is ignored. Changes to base, exp or mod during a run do not alter that run's result or timing.
- R9: The result stays unchanged from the done pulse until the next accepted start.
- R10: After reset, busy, done and result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only while idle |
| base_i | input | 32 | Base (message or cipher value) |
| exp_i | input | 32 | Exponent, used as a pass count |
| mod_i | input | 32 | Modulus |
| result_o | output | 32 | Result of the last completed run |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse when the result becomes valid |

## Verification
The assertions assume that start is sampled only at clock edges and that base, exp and mod are stable in any cycle where start is high and the engine is idle. The bench drives every input at the falling edge, so each accepted start sees settled operands. The bench also deliberately changes the operands and pulses start in the middle of a run, to show that those values are never consulted. The assertions make no assumption about operand range. The stimulus covers moduli of 0 and 1, bases above the modulus, and operands near 2^32.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
    localparam int unsigned DEF_OPW = 32;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PREP = 2'd1,
        PH_PASS = 2'd2
    } phase_e;
endpackage

// File: rtl/modexp_mulstep.sv
// One iteration of interleaved modular multiplication:
// acc' = (2*acc + bit*a) mod n, given acc < n and a < n.
module modexp_mulstep #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] n_i,
    input  logic         bit_i,
    output logic [W-1:0] acc_o
);
    logic [W:0] n_x, dbl, dbl_r, sum, sum_r;

    always_comb begin
        n_x   = {1'b0, n_i};
        dbl   = {acc_i, 1'b0};
        dbl_r = (dbl >= n_x) ? dbl - n_x : dbl;
        sum   = bit_i ? dbl_r + {1'b0, a_i} : dbl_r;
        sum_r = (sum >= n_x) ? sum - n_x : sum;
        acc_o = sum_r[W-1:0];
    end
endmodule

// File: rtl/modexp_mulmod.sv
// Sequential a*b mod n, one multiplier bit per cycle, MSB first, W cycles.
module modexp_mulmod #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] n_i,
    output logic         last_o,
    output logic [W-1:0] res_o
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

    logic [W-1:0]  acc_q, b_q, acc_nxt;
    logic [CW-1:0] cnt_q;
    logic          run_q;

    modexp_mulstep #(.W(W)) step_i (
        .acc_i (acc_q),
        .a_i   (a_i),
        .n_i   (n_i),
        .bit_i (b_q[W-1]),
        .acc_o (acc_nxt)
    );

    assign last_o = run_q && (cnt_q == LAST_CNT);
    assign res_o  = acc_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            b_q   <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            acc_q <= '0;
            b_q   <= b_i;
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            acc_q <= acc_nxt;
            b_q   <= b_q << 1;
            cnt_q <= cnt_q + 1'b1;
            if (last_o) run_q <= 1'b0;
        end
    end
endmodule

// File: rtl/modexp_engine.sv
module modexp_engine
    import modexp_pkg::*;
#(
    parameter int unsigned W = DEF_OPW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] exp_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] result_o,
    output logic         busy_o,
    output logic         done_o
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    phase_e       phase_q;
    logic [W-1:0] n_q, bm_q, left_q, result_q;
    logic         ezero_q, busy_q, done_q;

    logic         accept, trivial, mul_load, mul_last;
    logic [W-1:0] mul_a, mul_b, mul_res;

    assign accept  = start_i && (phase_q == PH_IDLE);
    assign trivial = (mod_i < TWO);

    // Launch a multiply on a nontrivial start, or chain another pass.
    assign mul_load = (accept && !trivial) || (mul_last && (left_q != '0));
    // Prep pass computes base*1 mod n; later passes use the reduced base.
    assign mul_a = (phase_q == PH_PREP) ? ONE : bm_q;
    assign mul_b = (phase_q == PH_IDLE) ? base_i : mul_res;

    modexp_mulmod #(.W(W)) mul_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (mul_load),
        .a_i    (mul_a),
        .b_i    (mul_b),
        .n_i    (n_q),
        .last_o (mul_last),
        .res_o  (mul_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            n_q      <= '0;
            bm_q     <= '0;
            left_q   <= '0;
            ezero_q  <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        if (trivial) begin
                            result_q <= '0;
                            done_q   <= 1'b1;
                        end else begin
                            phase_q <= PH_PREP;
                            n_q     <= mod_i;
                            left_q  <= (exp_i == '0) ? '0 : exp_i - ONE;
                            ezero_q <= (exp_i == '0);
                            busy_q  <= 1'b1;
                        end
                    end
                end
                PH_PREP: begin
                    if (mul_last) begin
                        bm_q <= mul_res;
                        if (left_q == '0) begin
                            result_q <= ezero_q ? ONE : mul_res;
                            done_q   <= 1'b1;
                            busy_q   <= 1'b0;
                            phase_q  <= PH_IDLE;
                        end else begin
                            left_q  <= left_q - ONE;
                            phase_q <= PH_PASS;
                        end
                    end
                end
                PH_PASS: begin
                    if (mul_last) begin
                        if (left_q == '0) begin
                            result_q <= mul_res;
                            done_q   <= 1'b1;
                            busy_q   <= 1'b0;
                            phase_q  <= PH_IDLE;
                        end else begin
                            left_q <= left_q - ONE;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign result_o = result_q;
    assign busy_o   = busy_q;
    assign done_o   = done_q;
endmodule

// File: rtl/modexp_engine_chk.sv
module modexp_engine_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [W-1:0] mod_i,
    input logic [W-1:0] result_o,
    input logic         busy_o,
    input logic         done_o
);
    logic [W-1:0] cap_n;

    always_ff @(posedge clk) begin
        if (rst) cap_n <= '0;
        else if (start_i && !busy_o) cap_n <= mod_i;
    end

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r7_busy_ends_in_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    a_r8_busy_continues: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

    a_r5_small_mod: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && (mod_i < W'(2))) |=> (done_o && !busy_o && (result_o == '0)));

    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !busy_o) |=> $stable(result_o));

    a_r6_below_mod: assert property (@(posedge clk) disable iff (rst)
        (done_o && (cap_n >= W'(2))) |-> (result_o < cap_n));
endmodule

bind modexp_engine modexp_engine_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .mod_i    (mod_i),
    .result_o (result_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/modexp_engine_tb_top.sv
module modexp_engine_tb_top;
    localparam int W = 32;
    localparam int WATCHDOG = 190000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [W-1:0] base_i = '0, exp_i = '0, mod_i = '0;
    logic [W-1:0] result_o;
    logic         busy_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    modexp_engine #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
        .exp_i(exp_i), .mod_i(mod_i), .result_o(result_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    function automatic longint unsigned ref_pow(longint unsigned b, longint unsigned e,
                                                longint unsigned n);
        longint unsigned bm, r;
        if (n < 2) return 0;
        bm = b % n;
        if (e == 0) return 1;
        r = bm;
        for (longint unsigned i = 1; i < e; i++) r = (r * bm) % n;
        return r;
    endfunction

    // Behavioural cycle model
    bit              m_busy = 0, m_done = 0;
    longint unsigned m_result = 0, m_pending = 0, m_left = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_result = 0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_result = m_pending;
                end
            end else if (start_i) begin
                if (mod_i < 2) begin
                    m_result = 0; m_done = 1;
                end else begin
                    m_busy = 1;
                    m_left = W * ((exp_i == 0) ? 1 : longint'(exp_i));
                    m_pending = ref_pow(base_i, exp_i, mod_i);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (busy_o !== m_busy) begin
                errors++;
                $display("FAIL R7 busy act=%0d exp=%0d at %0t", busy_o, m_busy, $time);
            end
            checks++;
            if (done_o !== m_done) begin
                errors++;
                $display("FAIL R7 done act=%0d exp=%0d at %0t", done_o, m_done, $time);
            end
            checks++;
            if (result_o !== W'(m_result)) begin
                errors++;
                $display("FAIL R1 result act=%0h exp=%0h at %0t", result_o, W'(m_result), $time);
            end
        end
    end

    task automatic check(string tag, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run(logic [W-1:0] b, logic [W-1:0] e, logic [W-1:0] n,
                       string tag, longint unsigned exp);
        @(negedge clk);
        base_i = b; exp_i = e; mod_i = n; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        check(tag, result_o, exp);
        repeat (3) @(negedge clk);
        check({tag, " R9 hold"}, result_o, exp);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < WATCHDOG && !finished) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired act=%0d exp=done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc0;
        longint unsigned step_exp [5] = '{123, 2197, 1892, 3173, 2319};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 busy", busy_o, 0);
        check("R10 done", done_o, 0);
        check("R10 result", result_o, 0);

        run(123, 17, 3233, "R1 123^17", 855);
        run('h64, 3, 'h21, "R1 0x64^3", 1);
        run('hFFFFFFFA, 3, 'hFFFFFFFB, "R1 wide", 'hFFFFFFFA);
        for (int k = 1; k <= 5; k++) run(123, W'(k), 3233, "R3 step", step_exp[k-1]);
        run(3233 + 123, 17, 3233, "R6 base>=n", 855);
        run('hFFFFFFFF, 1, 3233, "R6 base max", ref_pow('hFFFFFFFF, 1, 3233));
        run(3233, 4, 3233, "R6 base==n", 0);
        run(5, 0, 3233, "R4 exp0", 1);
        run(77, 9, 0, "R5 mod0", 0);
        run(77, 0, 1, "R5 mod1", 0);

        // R7: count busy cycles for exponent 3
        @(negedge clk);
        base_i = 9; exp_i = 3; mod_i = 1000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc0 = 0;
        while (busy_o) begin cyc0++; @(negedge clk); end
        check("R7 busy length", cyc0, 96);
        check("R7 done after busy", done_o, 1);
        check("R7 result", result_o, 729);

        // R8: start and operand changes during a run are ignored
        @(negedge clk);
        base_i = 123; exp_i = 17; mod_i = 3233; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (100) @(negedge clk);
        base_i = 7; exp_i = 2; mod_i = 11; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; base_i = 1; exp_i = 1; mod_i = 0;
        while (!done_o) @(negedge clk);
        check("R8 ignored start", result_o, 855);

        run(855, 2753, 3233, "R2 decrypt", 123);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule